// File: doc/BRIEF.md
# Sound Channel Enable and Status Register

This block is the single control and status register of a five-channel sound generator. The five channels are two pulse channels, a triangle channel, a noise channel and a sample-playback channel. A bus write latches one enable bit per channel. In the same cycle it emits one-cycle strobes to the channel counters: a length-counter clear for each tone or noise channel written as disabled, and either a stop or a restart for the sample channel. Every write also clears the sample channel's interrupt flag.

A bus read returns a packed status byte. The byte is built from the channels' activity inputs and the two interrupt flags the block stores. The read clears the frame interrupt as a side effect. The channel generators, the frame sequencer and the sample fetch unit sit outside the block. They connect only through activity inputs and interrupt set pulses. A set pulse that arrives in the same cycle as a clearing access wins: the flag reads as 1 and stays set.

Top module: `snd_chan_ctl`

## Requirements
- R1: On a cycle with `wr_en` high, `chan_en` takes `wdata[4:0]` at the clock edge (bit 0 pulse 1, bit 1 pulse 2, bit 2 triangle, bit 3 noise, bit 4 sample); otherwise it holds.
- R2: On a write, `len_clr[i]` is high in that same cycle for each `i` in 0..3 where `wdata[i]` is 0.
- R3: Any write clears the sample interrupt flag at the clock edge, whatever the data value.
- R4: A write with `wdata[4]` = 0 raises `smp_stop` (remaining-byte count to zero; the buffered byte keeps playing) and never `smp_restart`.
- R5: A write with `wdata[4]` = 1 raises `smp_restart` only when `smp_bytes_nz` is 0; otherwise no sample strobe fires.
- R6: `rdata` is {sample irq, frame irq, 0, `smp_bytes_nz`, `len_nz[3]`, `len_nz[2]`, `len_nz[1]`, `len_nz[0]`} from bit 7 to bit 0.
- R7: A read clears the frame interrupt flag at the clock edge and leaves the sample interrupt flag unchanged.
- R8: When a set pulse meets a clearing access in the same cycle, `rdata` shows 1 for that flag and the flag stays set.
- R9: `len_clr`, `smp_stop` and `smp_restart` are low on every cycle without `wr_en`. A cycle without `rd_en` never clears the frame flag.
- R10: `irq` is high exactly when either stored flag is set.
- R11: After reset, `chan_en` is 0, both flags are 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write qualifier |
| rd_en | input | 1 | Register read qualifier |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Status byte |
| len_nz | input | 4 | Length counter nonzero: pulse 1, pulse 2, triangle, noise |
| smp_bytes_nz | input | 1 | Sample remaining-byte count nonzero |
| frame_irq_set | input | 1 | Frame interrupt set pulse |
| smp_irq_set | input | 1 | Sample interrupt set pulse |
| chan_en | output | 5 | Latched channel enables |
| len_clr | output | 4 | Length-counter clear strobes |
| smp_stop | output | 1 | Zero the sample remaining-byte count |
| smp_restart | output | 1 | Restart sample playback |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check on every cycle that enables follow the written data, and that no strobe fires outside a write. They also check that restart never fires while bytes remain, and that the flags clear or survive as the access and set pulse in that cycle demand. Only the bench scenarios can show the exact bit packing of the status byte and the coincident set-and-read values seen on `rdata`. The same holds for long random mixes of reads, writes and set pulses checked against a reference model.

// File: rtl/snd_chan_ctl.sv
module snd_chan_ctl #(
  parameter int TONE_CH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  input  logic [TONE_CH-1:0] len_nz,
  input  logic               smp_bytes_nz,
  input  logic               frame_irq_set,
  input  logic               smp_irq_set,
  output logic [TONE_CH:0]   chan_en,
  output logic [TONE_CH-1:0] len_clr,
  output logic               smp_stop,
  output logic               smp_restart,
  output logic               irq
);
  localparam int SMP = TONE_CH;

  logic frm_q, smp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_en <= '0;
      frm_q   <= 1'b0;
      smp_q   <= 1'b0;
    end else begin
      if (wr_en) chan_en <= wdata[SMP:0];
      if (frame_irq_set)   frm_q <= 1'b1;
      else if (rd_en)      frm_q <= 1'b0;
      if (smp_irq_set)     smp_q <= 1'b1;
      else if (wr_en)      smp_q <= 1'b0;
    end
  end

  assign len_clr     = wr_en ? ~wdata[TONE_CH-1:0] : '0;
  assign smp_stop    = wr_en & ~wdata[SMP];
  assign smp_restart = wr_en & wdata[SMP] & ~smp_bytes_nz;
  assign rdata       = {smp_q | smp_irq_set, frm_q | frame_irq_set, 1'b0, smp_bytes_nz, len_nz};
  assign irq         = frm_q | smp_q;

  p_en_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> chan_en == $past(wdata[SMP:0]));
  p_en_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(chan_en));
  p_wr_clears_smp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !smp_irq_set |=> !smp_q);
  p_stop_no_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stop |-> !smp_restart);
  p_restart_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    smp_restart |-> !smp_bytes_nz);
  p_rd_clears_frm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !frame_irq_set |=> !frm_q);
  p_rd_keeps_smp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !wr_en && smp_q |=> smp_q);
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq_set |=> frm_q);
  p_strobe_wr_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (len_clr == '0) && !smp_stop && !smp_restart);
  p_frm_no_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en && frm_q |=> frm_q);
endmodule

// File: tb/snd_chan_ctl_bench.sv
`timescale 1ns/1ps
module snd_chan_ctl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, smp_bytes_nz = 0, frame_irq_set = 0, smp_irq_set = 0;
  logic [7:0] wdata = 0, rdata;
  logic [3:0] len_nz = 0, len_clr;
  logic [4:0] chan_en;
  logic smp_stop, smp_restart, irq;
  int checks = 0, errors = 0;
  logic [4:0] m_en;
  logic m_frm, m_smp;

  always #2 clk = ~clk;

  snd_chan_ctl u_snd_chan_ctl (.clk, .rst_n, .wr_en, .rd_en, .wdata, .rdata, .len_nz,
    .smp_bytes_nz, .frame_irq_set, .smp_irq_set, .chan_en, .len_clr, .smp_stop,
    .smp_restart, .irq);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic frm, logic smp, logic fs, logic ss,
                                        logic bnz, logic [3:0] lnz);
    return {smp | ss, frm | fs, 1'b0, bnz, lnz};
  endfunction

  function automatic logic [5:0] exp_strobes(logic wr, logic [7:0] wd, logic bnz);
    return {wr & ~wd[4], wr & wd[4] & ~bnz, wr ? ~wd[3:0] : 4'h0};
  endfunction

  task automatic step(logic wr, logic rd, logic [7:0] wd, logic [3:0] lnz,
                      logic bnz, logic fs, logic ss);
    @(negedge clk);
    chk("R1 chan_en", {3'b0, chan_en}, {3'b0, m_en});
    chk("R10 irq", {7'b0, irq}, {7'b0, m_frm | m_smp});
    wr_en = wr; rd_en = rd; wdata = wd; len_nz = lnz; smp_bytes_nz = bnz;
    frame_irq_set = fs; smp_irq_set = ss;
    #1;
    chk("R6 R8 rdata", rdata, exp_rd(m_frm, m_smp, fs, ss, bnz, lnz));
    chk("R2 R4 R5 R9 strobes", {2'b0, smp_stop, smp_restart, len_clr},
        {2'b0, exp_strobes(wr, wd, bnz)});
    @(posedge clk);
    if (wr) m_en = wd[4:0];
    m_frm = fs ? 1'b1 : (rd ? 1'b0 : m_frm);
    m_smp = ss ? 1'b1 : (wr ? 1'b0 : m_smp);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_en = 0; m_frm = 0; m_smp = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R11 reset chan_en", {3'b0, chan_en}, 8'h00);
    chk("R11 reset irq", {7'b0, irq}, 8'h00);
    // R8: set both flags, then read with frame set pulse: flag stays
    step(0, 0, 8'h00, 4'h5, 1, 1, 1);
    step(0, 1, 8'h00, 4'hA, 0, 1, 0);
    // R7: plain read clears frame only
    step(0, 1, 8'h00, 4'h0, 0, 0, 0);
    step(0, 0, 8'h00, 4'h0, 0, 0, 0);
    // R3 with coincident sample set: sample flag stays (R8)
    step(1, 0, 8'h1F, 4'hF, 1, 0, 1);
    // R5: restart blocked while bytes remain, allowed when zero
    step(1, 0, 8'h10, 4'h0, 1, 0, 0);
    step(1, 0, 8'h10, 4'h0, 0, 0, 0);
    // R4 and R2: clear everything
    step(1, 0, 8'hE0, 4'hF, 1, 0, 0);
    // R9: idle cycle
    step(0, 0, 8'h00, 4'h3, 0, 0, 0);
    for (int i = 0; i < 500; i++)
      step(($urandom % 3) == 0, ($urandom % 3) == 0, 8'($urandom), 4'($urandom),
           1'($urandom), ($urandom % 5) == 0, ($urandom % 5) == 0);
    step(0, 0, 8'h00, 4'h0, 0, 0, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule